// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel that moves data items between a peripheral register at a fixed address and a memory buffer, so a processor does not have to copy them itself. Software loads the configuration with a single strobe. The configuration holds two base addresses, an item count, a direction, an increment enable and an item size for each side, a circular-mode bit, three interrupt enables and a channel enable. The peripheral then asks for one item at a time over a four-phase request/acknowledge handshake.

For every item the engine acts as a bus master and makes two accesses. First it reads the item from the source address into an internal holding register, resizing it to the destination width. Then it writes the holding register to the destination address. After that it decrements the remaining-item counter and acknowledges the peripheral. Sticky flags mark half-transfer, transfer-complete and bus error. A single interrupt line combines the flags whose enables are set. In circular mode the counter and both pointers reload, so the channel can keep a buffer streaming with no further software action.

Top module: `dma_chan_engine`

## Requirements
- R1: `periph_ack` rises one cycle after the destination write completes. It stays high while `periph_req` is high and falls on the clock after `periph_req` is seen low. No bus access takes place while `periph_ack` is high.
- R2: Each item is a read cycle (`bus_write`=0) at the source followed by a write cycle (`bus_write`=1) at the destination. With `cfg_to_periph`=0 the source is the peripheral address and the destination is the memory address. With `cfg_to_periph`=1 the two are swapped.
- R3: `remaining` loads from `cfg_count` on `cfg_we` and drops by one for each item whose write completes without error.
- R4: After a completed item, each side's pointer advances by that side's item size only if that side's increment enable is set; otherwise it holds. Size codes are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes. `bus_size` carries the code of the side being accessed.
- R5: Read data is right-aligned in `bus_rdata`. The item written is the read value, zero-extended or truncated to the destination size.
- R6: In circular mode, an item that brings the count to zero instead reloads the programmed count and returns both pointers to their base addresses, and the channel keeps serving requests.
- R7: `flag_ht` sets when the number of completed items equals the programmed count divided by two (rounded down), or equals 1 when that quotient is 0.
- R8: `flag_tc` sets when the count reaches zero. In non-circular mode no further request is served until the channel is reconfigured.
- R9: While `chan_enabled` is low, requests start no bus access and get no acknowledge.
- R10: `bus_err` during either access sets `flag_te`, clears the channel enable and abandons the item. The count does not change and no acknowledge is given.
- R11: The flags are sticky. Writing one to `flag_clr` bit 0, 1 or 2 clears `flag_ht`, `flag_tc` or `flag_te` respectively. A flag that is set in the same cycle wins over its clear.
- R12: `irq` is high whenever any flag is set together with its own interrupt enable.
- R13: While `bus_ready` is low and `bus_err` is low, the access in progress holds `bus_req`, `bus_write` and `bus_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load all configuration fields; returns the engine to idle |
| cfg_paddr | input | 32 | Peripheral base address |
| cfg_maddr | input | 32 | Memory base address |
| cfg_count | input | 16 | Items per pass, 1 to 65535 |
| cfg_to_periph | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_pinc | input | 1 | Peripheral pointer increment enable |
| cfg_minc | input | 1 | Memory pointer increment enable |
| cfg_psize | input | 2 | Peripheral item size code |
| cfg_msize | input | 2 | Memory item size code |
| cfg_circular | input | 1 | Circular reload enable |
| cfg_ht_ie | input | 1 | Half-transfer interrupt enable |
| cfg_tc_ie | input | 1 | Transfer-complete interrupt enable |
| cfg_te_ie | input | 1 | Transfer-error interrupt enable |
| cfg_enable | input | 1 | Channel enable |
| flag_clr | input | 3 | Write-one clear: bit0 half, bit1 complete, bit2 error |
| periph_req | input | 1 | Peripheral item request |
| periph_ack | output | 1 | Item acknowledge |
| bus_req | output | 1 | Bus access request |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | Size code of the access |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_rdata | input | 32 | Read data, right-aligned |
| bus_ready | input | 1 | Access completes on this clock |
| bus_err | input | 1 | Access failed |
| flag_ht | output | 1 | Half-transfer flag |
| flag_tc | output | 1 | Transfer-complete flag |
| flag_te | output | 1 | Transfer-error flag |
| irq | output | 1 | Combined interrupt |
| remaining | output | 16 | Items left in the current pass |
| chan_enabled | output | 1 | Channel enable state |

## Verification
A request seen at a clock edge opens the read access on the next cycle. A read accepted with `bus_ready` opens the write access on the cycle after it. The edge that accepts the write also updates `remaining`, the pointers and the flags, and raises `periph_ack` in the same cycle. The bench keeps a behavioural model that it advances at mid-cycle from the same handshake inputs that the design samples at the following edge, and compares every output against the model once per cycle, so each result is checked in exactly the cycle it is due. Extra directed checks read the modelled memory after each sequence to confirm zero-extension, truncation and circular wrap.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } item_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_ACK
    } xfer_state_e;

    typedef struct packed {
        logic       to_periph;
        logic       p_inc;
        logic       m_inc;
        item_size_e p_size;
        item_size_e m_size;
        logic       circular;
        logic       ht_ie;
        logic       tc_ie;
        logic       te_ie;
        logic       enable;
    } chan_mode_t;

    // byte stride of one item
    function automatic logic [2:0] size_step(item_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(item_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // keep the source item, then cut it to the destination width
    function automatic logic [WORD_W-1:0] fit_item(logic [WORD_W-1:0] d,
                                                   item_size_e src,
                                                   item_size_e dst);
        return d & lane_mask(src) & lane_mask(dst);
    endfunction

endpackage

// File: rtl/dma_ptr.sv
module dma_ptr
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              advance,
    input  logic              rewind,
    input  logic              inc_en,
    input  item_size_e        size,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            cur_q  <= base_in;
        end else if (rewind) begin
            cur_q <= base_q;
        end else if (advance && inc_en) begin
            cur_q <= cur_q + ADDR_W'(size_step(size));
        end
    end

    assign addr = cur_q;

    // R4: a side without increment keeps its address across an item
    p_fixed_side_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && !inc_en && !load && !rewind) |=> $stable(addr));

    // R6: a rewind returns the pointer to its programmed base
    p_rewind_base_r6: assert property (@(posedge clk) disable iff (rst)
        (rewind && !load) |=> (addr == base_q));

endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic go,
    input  logic periph_req,
    input  logic bus_ready,
    input  logic bus_err,
    output logic periph_ack,
    output logic bus_req,
    output logic bus_write,
    output logic rd_done,
    output logic wr_done,
    output logic xfer_err
);

    xfer_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (go && periph_req) state_d = ST_READ;
            ST_READ:  if (bus_err) state_d = ST_IDLE;
                      else if (bus_ready) state_d = ST_WRITE;
            ST_WRITE: if (bus_err) state_d = ST_IDLE;
                      else if (bus_ready) state_d = ST_ACK;
            ST_ACK:   if (!periph_req) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign bus_req    = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign bus_write  = (state_q == ST_WRITE);
    assign periph_ack = (state_q == ST_ACK);
    assign rd_done    = (state_q == ST_READ)  && bus_ready && !bus_err;
    assign wr_done    = (state_q == ST_WRITE) && bus_ready && !bus_err;
    assign xfer_err   = bus_req && bus_err;

    // R1: acknowledge is held for as long as the request stays up
    p_ack_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (periph_ack && periph_req && !abort) |=> periph_ack);

    // R1: no bus traffic while the handshake is closing
    p_ack_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        periph_ack |-> !bus_req);

    // R1: acknowledge only follows a completed write
    p_ack_after_write_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(periph_ack) |-> $past(wr_done));

    // R13: a stalled access keeps its command
    p_stall_cmd_r13: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready && !bus_err && !abort) |=> (bus_req && $stable(bus_write)));

endmodule

// File: rtl/dma_flag_unit.sv
module dma_flag_unit (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_ht,
    input  logic       set_tc,
    input  logic       set_te,
    input  logic [2:0] clr,
    input  logic       ht_ie,
    input  logic       tc_ie,
    input  logic       te_ie,
    output logic       flag_ht,
    output logic       flag_tc,
    output logic       flag_te,
    output logic       irq
);

    logic [2:0] flags_q;
    logic [2:0] sets;

    assign sets = {set_te, set_tc, set_ht};

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr) | sets;
    end

    assign flag_ht = flags_q[0];
    assign flag_tc = flags_q[1];
    assign flag_te = flags_q[2];
    assign irq     = |(flags_q & {te_ie, tc_ie, ht_ie});

    // R11: a set flag survives until its clear bit is written
    p_sticky_ht_r11: assert property (@(posedge clk) disable iff (rst)
        (flag_ht && !clr[0]) |=> flag_ht);
    p_sticky_tc_r11: assert property (@(posedge clk) disable iff (rst)
        (flag_tc && !clr[1]) |=> flag_tc);
    p_sticky_te_r11: assert property (@(posedge clk) disable iff (rst)
        (flag_te && !clr[2]) |=> flag_te);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_paddr,
    input  logic [ADDR_W-1:0] cfg_maddr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_to_periph,
    input  logic              cfg_pinc,
    input  logic              cfg_minc,
    input  logic [1:0]        cfg_psize,
    input  logic [1:0]        cfg_msize,
    input  logic              cfg_circular,
    input  logic              cfg_ht_ie,
    input  logic              cfg_tc_ie,
    input  logic              cfg_te_ie,
    input  logic              cfg_enable,
    input  logic [2:0]        flag_clr,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    output logic              flag_ht,
    output logic              flag_tc,
    output logic              flag_te,
    output logic              irq,
    output logic [CNT_W-1:0]  remaining,
    output logic              chan_enabled
);

    localparam int unsigned NSIDE  = 2;   // 0: peripheral, 1: memory
    localparam int unsigned SIDE_P = 0;
    localparam int unsigned SIDE_M = 1;

    chan_mode_t         mode_q;
    logic [CNT_W-1:0]   init_q;
    logic [CNT_W-1:0]   count_q;
    logic [WORD_W-1:0]  hold_q;

    logic rd_done, wr_done, xfer_err;
    logic last_item, wrap, go;
    logic [CNT_W-1:0] ht_point, done_after;
    logic src_idx, dst_idx;
    item_size_e src_size, dst_size;

    logic [ADDR_W-1:0] side_base [NSIDE];
    logic [ADDR_W-1:0] side_addr [NSIDE];
    logic              side_inc  [NSIDE];
    item_size_e        side_size [NSIDE];

    assign side_base[SIDE_P] = cfg_paddr;
    assign side_base[SIDE_M] = cfg_maddr;
    assign side_inc[SIDE_P]  = mode_q.p_inc;
    assign side_inc[SIDE_M]  = mode_q.m_inc;
    assign side_size[SIDE_P] = mode_q.p_size;
    assign side_size[SIDE_M] = mode_q.m_size;

    // configuration and item counter
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            init_q  <= '0;
            count_q <= '0;
        end else if (cfg_we) begin
            mode_q.to_periph <= cfg_to_periph;
            mode_q.p_inc     <= cfg_pinc;
            mode_q.m_inc     <= cfg_minc;
            mode_q.p_size    <= item_size_e'(cfg_psize);
            mode_q.m_size    <= item_size_e'(cfg_msize);
            mode_q.circular  <= cfg_circular;
            mode_q.ht_ie     <= cfg_ht_ie;
            mode_q.tc_ie     <= cfg_tc_ie;
            mode_q.te_ie     <= cfg_te_ie;
            mode_q.enable    <= cfg_enable;
            init_q           <= cfg_count;
            count_q          <= cfg_count;
        end else if (xfer_err) begin
            mode_q.enable <= 1'b0;
        end else if (wr_done) begin
            count_q <= wrap ? init_q : (count_q - CNT_W'(1));
        end
    end

    assign last_item  = (count_q == CNT_W'(1));
    assign wrap       = wr_done && last_item && mode_q.circular;
    assign go         = mode_q.enable && (count_q != '0);
    assign ht_point   = ((init_q >> 1) == '0) ? CNT_W'(1) : (init_q >> 1);
    assign done_after = init_q - count_q + CNT_W'(1);

    assign src_idx  = mode_q.to_periph;
    assign dst_idx  = !mode_q.to_periph;
    assign src_size = side_size[src_idx];
    assign dst_size = side_size[dst_idx];

    generate
        for (genvar g = 0; g < NSIDE; g++) begin : g_side
            dma_ptr #(.ADDR_W(ADDR_W)) u_ptr (
                .clk     (clk),
                .rst     (rst),
                .load    (cfg_we),
                .base_in (side_base[g]),
                .advance (wr_done && !cfg_we),
                .rewind  (wrap && !cfg_we),
                .inc_en  (side_inc[g]),
                .size    (side_size[g]),
                .addr    (side_addr[g])
            );
        end
    endgenerate

    dma_xfer_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .abort      (cfg_we),
        .go         (go),
        .periph_req (periph_req),
        .bus_ready  (bus_ready),
        .bus_err    (bus_err),
        .periph_ack (periph_ack),
        .bus_req    (bus_req),
        .bus_write  (bus_write),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .xfer_err   (xfer_err)
    );

    // holding register between the two accesses
    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (rd_done) hold_q <= fit_item(bus_rdata, src_size, dst_size);
    end

    dma_flag_unit u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_ht  (wr_done && !cfg_we && (done_after == ht_point)),
        .set_tc  (wr_done && !cfg_we && last_item),
        .set_te  (xfer_err && !cfg_we),
        .clr     (flag_clr),
        .ht_ie   (mode_q.ht_ie),
        .tc_ie   (mode_q.tc_ie),
        .te_ie   (mode_q.te_ie),
        .flag_ht (flag_ht),
        .flag_tc (flag_tc),
        .flag_te (flag_te),
        .irq     (irq)
    );

    assign bus_addr     = bus_write ? side_addr[dst_idx] : side_addr[src_idx];
    assign bus_size     = bus_write ? dst_size : src_size;
    assign bus_wdata    = hold_q;
    assign remaining    = count_q;
    assign chan_enabled = mode_q.enable;

    // R3: a clean item removes exactly one from the count
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !cfg_we && (count_q > CNT_W'(1))) |=> (remaining == $past(remaining) - CNT_W'(1)));

    // R6: the last item of a circular pass restores the full count
    p_wrap_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !cfg_we && last_item && mode_q.circular) |=> (remaining == init_q));

    // R10: a bus error stops the channel and flags it, count untouched
    p_err_stop_r10: assert property (@(posedge clk) disable iff (rst)
        (xfer_err && !cfg_we) |=> (!chan_enabled && flag_te && $stable(remaining)));

    // R9: a disabled channel does not drive the bus
    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        !chan_enabled |-> !bus_req);

    // R13: a stalled access keeps its address
    p_stall_addr_r13: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready && !bus_err && !cfg_we) |=> $stable(bus_addr));

endmodule

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_paddr = '0, cfg_maddr = '0;
    logic [15:0] cfg_count = '0;
    logic        cfg_to_periph = 1'b0, cfg_pinc = 1'b0, cfg_minc = 1'b0;
    logic [1:0]  cfg_psize = '0, cfg_msize = '0;
    logic        cfg_circular = 1'b0, cfg_ht_ie = 1'b0, cfg_tc_ie = 1'b0;
    logic        cfg_te_ie = 1'b0, cfg_enable = 1'b0;
    logic [2:0]  flag_clr = '0;
    logic        periph_req = 1'b0;
    logic        periph_ack, bus_req, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0, bus_err = 1'b0;
    logic        flag_ht, flag_tc, flag_te, irq, chan_enabled;
    logic [15:0] remaining;

    always #10 clk = ~clk;   // 50 MHz

    dma_chan_engine uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_paddr(cfg_paddr), .cfg_maddr(cfg_maddr), .cfg_count(cfg_count),
        .cfg_to_periph(cfg_to_periph), .cfg_pinc(cfg_pinc), .cfg_minc(cfg_minc),
        .cfg_psize(cfg_psize), .cfg_msize(cfg_msize), .cfg_circular(cfg_circular),
        .cfg_ht_ie(cfg_ht_ie), .cfg_tc_ie(cfg_tc_ie), .cfg_te_ie(cfg_te_ie),
        .cfg_enable(cfg_enable), .flag_clr(flag_clr),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err),
        .flag_ht(flag_ht), .flag_tc(flag_tc), .flag_te(flag_te), .irq(irq),
        .remaining(remaining), .chan_enabled(chan_enabled)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // byte-addressed memory seen by the bus (256 bytes, address wraps)
    logic [7:0] mem [256];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {mem[a[7:0]+8'd3], mem[a[7:0]+8'd2], mem[a[7:0]+8'd1], mem[a[7:0]]};
    endfunction

    function automatic int nbytes(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [31:0] bmask(input int n);
        return (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // behavioural reference model
    logic [31:0] m_pbase, m_mbase, m_paddr, m_maddr, m_hold;
    int          m_init = 0, m_count = 0;
    bit          m_dir, m_pinc, m_minc, m_circ, m_htie, m_tcie, m_teie, m_en;
    logic [1:0]  m_ps, m_ms;
    bit          m_phase = 0, m_done = 0, m_ht = 0, m_tc = 0, m_te = 0;
    bit          prev_ack = 0, stall_prev = 0, slow = 0, inject_err = 0;
    logic [31:0] prev_addr = '0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        if (rst) begin
            m_en = 0; m_count = 0; m_phase = 0; m_done = 0;
            m_ht = 0; m_tc = 0; m_te = 0; prev_ack = 0; stall_prev = 0;
            m_htie = 0; m_tcie = 0; m_teie = 0;
            bus_ready = 1'b0; bus_err = 1'b0;
        end else begin
            bit          ack_rise, rdy, err;
            int          sb, db, done_n, hp;
            logic [31:0] exp_addr;
            ack_rise = periph_ack && !prev_ack;
            chk(remaining == 16'(m_count), "R3", remaining, m_count);
            chk(flag_ht == m_ht, "R7", flag_ht, m_ht);
            chk(flag_tc == m_tc, "R8", flag_tc, m_tc);
            chk(flag_te == m_te, "R10", flag_te, m_te);
            chk(irq == ((m_ht && m_htie) || (m_tc && m_tcie) || (m_te && m_teie)), "R12",
                irq, (m_ht && m_htie) || (m_tc && m_tcie) || (m_te && m_teie));
            chk(chan_enabled == m_en, "R9", chan_enabled, m_en);
            chk(ack_rise == m_done, "R1", ack_rise, m_done);
            if (periph_ack) chk(!bus_req, "R1", bus_req, 0);
            if (stall_prev) chk(bus_req && bus_addr == prev_addr, "R13", bus_addr, prev_addr);
            sb = m_dir ? nbytes(m_ms) : nbytes(m_ps);
            db = m_dir ? nbytes(m_ps) : nbytes(m_ms);
            if (bus_req) begin
                chk(m_en && m_count != 0, "R9", bus_req, 0);
                chk(bus_write == m_phase, "R2", bus_write, m_phase);
                exp_addr = (m_phase ^ m_dir) ? m_maddr : m_paddr;
                chk(bus_addr == exp_addr, "R4", bus_addr, exp_addr);
                chk(bus_size == ((m_phase ^ m_dir) ? m_ms : m_ps), "R4", bus_size,
                    (m_phase ^ m_dir) ? m_ms : m_ps);
                if (m_phase) chk(bus_wdata == m_hold, "R5", bus_wdata, m_hold);
            end
            // bus responder
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = slow ? lfsr[0] : 1'b1;
            err = bus_req && m_phase && inject_err;
            if (err) inject_err = 0;
            bus_ready = rdy;
            bus_err   = err;
            bus_rdata = bus_req ? mem_word(bus_addr) : 32'h0;
            stall_prev = bus_req && !rdy && !err;
            prev_addr  = bus_addr;
            prev_ack   = periph_ack;
            m_done = 0;
            // model step for the coming edge
            if (cfg_we) begin
                m_pbase = cfg_paddr; m_mbase = cfg_maddr;
                m_paddr = cfg_paddr; m_maddr = cfg_maddr;
                m_init = cfg_count; m_count = cfg_count;
                m_dir = cfg_to_periph; m_pinc = cfg_pinc; m_minc = cfg_minc;
                m_ps = cfg_psize; m_ms = cfg_msize; m_circ = cfg_circular;
                m_htie = cfg_ht_ie; m_tcie = cfg_tc_ie; m_teie = cfg_te_ie;
                m_en = cfg_enable; m_phase = 0;
            end else begin
                if (flag_clr[0]) m_ht = 0;
                if (flag_clr[1]) m_tc = 0;
                if (flag_clr[2]) m_te = 0;
                if (bus_req && err) begin
                    m_te = 1; m_en = 0; m_phase = 0;
                end else if (bus_req && rdy) begin
                    if (!m_phase) begin
                        m_hold  = bus_rdata & bmask((sb < db) ? sb : db);
                        m_phase = 1;
                    end else begin
                        for (int k = 0; k < db; k++)
                            mem[bus_addr[7:0] + 8'(k)] = bus_wdata[8*k +: 8];
                        m_phase = 0;
                        m_done  = 1;
                        done_n  = m_init - m_count + 1;
                        hp      = (m_init / 2 == 0) ? 1 : m_init / 2;
                        if (done_n == hp) m_ht = 1;
                        if (m_count == 1 && m_circ) begin
                            m_tc = 1; m_count = m_init;
                            m_paddr = m_pbase; m_maddr = m_mbase;
                        end else begin
                            if (m_count == 1) m_tc = 1;
                            m_count = m_count - 1;
                            if (m_pinc) m_paddr = m_paddr + nbytes(m_ps);
                            if (m_minc) m_maddr = m_maddr + nbytes(m_ms);
                        end
                    end
                end
            end
        end
    end

    task automatic configure(input logic [31:0] pa, input logic [31:0] ma, input logic [15:0] n,
                             input bit dir, input bit pinc, input bit minc,
                             input logic [1:0] ps, input logic [1:0] ms, input bit circ,
                             input bit hti, input bit tci, input bit tei, input bit en);
        @(posedge clk); #5;
        cfg_paddr = pa; cfg_maddr = ma; cfg_count = n; cfg_to_periph = dir;
        cfg_pinc = pinc; cfg_minc = minc; cfg_psize = ps; cfg_msize = ms;
        cfg_circular = circ; cfg_ht_ie = hti; cfg_tc_ie = tci; cfg_te_ie = tei;
        cfg_enable = en; cfg_we = 1'b1;
        @(posedge clk); #5 cfg_we = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] bits);
        @(posedge clk); #5 flag_clr = bits;
        @(posedge clk); #5 flag_clr = 3'b000;
    endtask

    // one full four-phase handshake
    task automatic serve_item();
        bit got = 0;
        @(posedge clk); #5 periph_req = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (periph_ack) begin got = 1; break; end
        end
        chk(got, "R1", got, 1);
        @(posedge clk); #5 periph_req = 1'b0;
        @(negedge clk); chk(periph_ack, "R1", periph_ack, 1);
        @(negedge clk); chk(!periph_ack, "R1", periph_ack, 0);
    endtask

    // a request that must get no acknowledge
    task automatic refused_item(input string tag);
        @(posedge clk); #5 periph_req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); chk(!periph_ack, tag, periph_ack, 0);
        end
        @(posedge clk); #5 periph_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        @(negedge clk);
        chk(!periph_ack && !bus_req, "R1", {periph_ack, bus_req}, 0);
        chk(remaining == 16'd0, "R3", remaining, 0);
        chk(!flag_ht && !flag_tc && !flag_te && !irq, "R11", {flag_ht, flag_tc, flag_te, irq}, 0);
        chk(!chan_enabled, "R9", chan_enabled, 0);

        // peripheral byte -> memory word, fixed source, counting memory
        configure(32'h40, 32'h80, 16'd4, 0, 0, 1, 2'b00, 2'b10, 0, 1, 1, 0, 1);
        serve_item();
        @(negedge clk); chk(!flag_ht && remaining == 16'd3, "R7", {flag_ht, remaining}, 3);
        serve_item();
        @(negedge clk); chk(flag_ht, "R7", flag_ht, 1);
        serve_item();
        serve_item();
        @(negedge clk);
        chk(remaining == 16'd0 && flag_tc, "R8", {flag_tc, remaining}, 32'h10000);
        chk(irq, "R12", irq, 1);
        chk(mem_word(32'h8C) == 32'h0000_00C3, "R5", mem_word(32'h8C), 32'hC3);
        chk(mem_word(32'h80) == 32'h0000_00C3, "R2", mem_word(32'h80), 32'hC3);
        chk(mem[8'h90] == 8'((8'h90) * 7 + 3), "R4", mem[8'h90], 8'((8'h90) * 7 + 3));
        refused_item("R8");
        chk(remaining == 16'd0, "R8", remaining, 0);

        clear_flags(3'b011);
        @(negedge clk);
        chk(!flag_ht && !flag_tc && !irq, "R11", {flag_ht, flag_tc, irq}, 0);

        // channel loaded but disabled
        configure(32'h40, 32'h80, 16'd2, 0, 0, 1, 2'b00, 2'b00, 0, 1, 1, 1, 0);
        refused_item("R9");
        chk(remaining == 16'd2 && !chan_enabled, "R9", remaining, 2);

        // memory word -> peripheral half, circular, with wait states
        configure(32'h60, 32'h10, 16'd3, 1, 0, 1, 2'b01, 2'b10, 1, 0, 1, 0, 1);
        slow = 1;
        for (int i = 0; i < 7; i++) serve_item();
        slow = 0;
        @(negedge clk);
        chk(remaining == 16'd2, "R6", remaining, 2);
        chk(chan_enabled && flag_tc, "R6", {chan_enabled, flag_tc}, 3);
        chk(mem[8'h60] == 8'h73 && mem[8'h61] == 8'h7A, "R5", {mem[8'h61], mem[8'h60]}, 16'h7A73);
        chk(mem[8'h62] == 8'hB1, "R5", mem[8'h62], 8'hB1);

        clear_flags(3'b111);

        // single-item pass: both flags together
        configure(32'h40, 32'hA0, 16'd1, 0, 1, 1, 2'b00, 2'b00, 0, 1, 0, 0, 1);
        serve_item();
        @(negedge clk);
        chk(flag_ht && flag_tc, "R7", {flag_ht, flag_tc}, 3);
        chk(irq, "R12", irq, 1);
        chk(mem[8'hA0] == 8'hC3, "R2", mem[8'hA0], 8'hC3);
        clear_flags(3'b011);

        // bus error on the write access
        configure(32'h40, 32'hB0, 16'd5, 0, 0, 1, 2'b00, 2'b10, 0, 0, 0, 1, 1);
        serve_item();
        @(negedge clk); chk(remaining == 16'd4, "R3", remaining, 4);
        inject_err = 1;
        refused_item("R10");
        chk(flag_te && !chan_enabled && remaining == 16'd4, "R10", {flag_te, chan_enabled, remaining}, 32'h20004);
        chk(irq, "R12", irq, 1);
        refused_item("R9");
        clear_flags(3'b100);
        @(negedge clk);
        chk(!flag_te && !irq, "R11", {flag_te, irq}, 0);

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule